// File: doc/BRIEF.md
# Windowed Watchdog Timer

This peripheral watches software liveness with a 7-bit down-counter that software must reload. The counter only moves while the watchdog is running. It steps down on a slow time base: a free-running prescaler divides the peripheral clock by a base factor (4096 by default), and then by 1, 2, 4 or 8. Once the counter leaves the 0x40..0x7F half of its range, the block asks the system for a reset. Software can reload the counter to avoid this, but only inside a window. A reload made while the count is still above the programmed window value is treated as a fault and also causes a reset request.

Software gets a warning one step before the timeout. When the counter reaches 0x40, a status flag is set, and an interrupt line carries that flag gated by an enable bit. Software sees three registers through a simple write strobe, a 2-bit address and a combinational read port. The enable bit and the interrupt enable can only be set by software; only a hardware reset clears them.

Top module: `win_watchdog`

## Requirements
- R1: Reset state. Address 0 reads 0x07F (count 0x7F, enable 0). Address 1 reads 0x07F (window 0x7F, prescaler 0, interrupt enable 0). Address 2 reads 0. Address 3 always reads 0. `rst_req` and `early_irq` are low.
- R2: The prescaler runs freely from reset. The counter drops by one once every BASE_DIV·2^psc clock cycles, and only while the enable bit is set. While disabled, the count holds.
- R3: Address 0 holds the count in bits [6:0] and the enable in bit 7. A write loads the count, and this takes priority over a decrement in the same cycle. Writing 1 to bit 7 sets the enable; writing 0 to bit 7 leaves it unchanged.
- R4: Address 1 holds the window in bits [6:0], the prescaler select in bits [8:7] and the interrupt enable in bit 9. Bit 9 can be set by a write but is never cleared by one.
- R5: When the counter is enabled, is at 0x40, receives a time-base step and is not written in that cycle, `rst_req` goes high in the following cycle.
- R6: A write to address 0 while the watchdog is already enabled and the count is above the window value raises `rst_req` in the following cycle. Such a write at or below the window raises nothing.
- R7: Status bit 0 is set by a step that takes an enabled counter from 0x41 to 0x40. A write to address 2 with bit 0 = 0 clears it, and a write with bit 0 = 1 leaves it unchanged. If a set and a clear happen in the same cycle, the set wins.
- R8: `early_irq` equals the status flag ANDed with the interrupt enable.
- R9: `rst_req` is high for one cycle per timeout or early-reload event and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register address: 0 control, 1 configuration, 2 status |
| bus_wdata | input | 10 | Write data |
| bus_rdata | output | 10 | Read data of the addressed register |
| rst_req | output | 1 | System reset request pulse |
| early_irq | output | 1 | Early-warning interrupt |

## Verification
The assertions assume that `bus_wr`, `bus_addr` and `bus_wdata` are stable around each rising edge, and that reset is held low from time zero until the first edges, so every registered value has a defined history before any property is evaluated. The stimulus changes these inputs only on falling edges and holds reset through the first few cycles. It keeps every write to a single cycle and uses only the four defined addresses, so any count change is explained by either a write or a time-base step.

// File: rtl/win_wdog_pkg.sv
package win_wdog_pkg;

  localparam int CNT_W = 7;
  localparam int REG_W = 10;
  localparam logic [CNT_W-1:0] CNT_WARN  = 7'h41;
  localparam logic [CNT_W-1:0] CNT_LAST  = 7'h40;
  localparam logic [CNT_W-1:0] CNT_RESET = 7'h7F;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CFG  = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_NONE = 2'd3
  } wd_addr_e;

  // One time-base step when the low bits of the free-running count are all ones.
  function automatic logic base_hit(input logic [31:0] pre,
                                    input logic [31:0] base,
                                    input logic [1:0]  sel);
    logic [31:0] mask;
    mask = (base << sel) - 32'd1;
    return (pre & mask) == mask;
  endfunction

  // Window fault: a reload while the count still sits above the window.
  function automatic logic too_early(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] win);
    return cnt > win;
  endfunction

endpackage

// File: rtl/win_wdog_timebase.sv
module win_wdog_timebase
  import win_wdog_pkg::*;
#(
  parameter int BASE_DIV = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] psc,
  output logic       tick
);

  localparam int PW = $clog2(BASE_DIV) + 3;

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign tick = base_hit(32'(pre_q), 32'(BASE_DIV), psc);

endmodule

// File: rtl/win_wdog_core.sv
module win_wdog_core
  import win_wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_data,
  input  logic [CNT_W-1:0] win,
  output logic [CNT_W-1:0] cnt_q,
  output logic             en_q,
  output logic             ew_evt,
  output logic             rst_req
);

  logic step;
  logic timeout_evt;
  logic early_evt;

  assign step        = en_q && tick && !ctl_wr;
  assign timeout_evt = step && (cnt_q == CNT_LAST);
  assign early_evt   = ctl_wr && en_q && too_early(cnt_q, win);
  assign ew_evt      = step && (cnt_q == CNT_WARN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_RESET;
      en_q    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (ctl_wr)    cnt_q <= ctl_data[CNT_W-1:0];
      else if (step) cnt_q <= cnt_q - 1'b1;
      en_q    <= en_q | (ctl_wr & ctl_data[7]);
      rst_req <= timeout_evt | early_evt;
    end
  end

endmodule

// File: rtl/win_wdog_cfg.sv
module win_wdog_cfg
  import win_wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             stat_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             ew_evt,
  output logic [CNT_W-1:0] win_q,
  output logic [1:0]       psc_q,
  output logic             ewi_q,
  output logic             flag_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= CNT_RESET;
      psc_q  <= 2'd0;
      ewi_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (cfg_wr) begin
        win_q <= wdata[CNT_W-1:0];
        psc_q <= wdata[8:7];
        ewi_q <= ewi_q | wdata[9];
      end
      if (ew_evt)                    flag_q <= 1'b1;
      else if (stat_wr && !wdata[0]) flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import win_wdog_pkg::*;
#(
  parameter int BASE_DIV = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             rst_req,
  output logic             early_irq
);

  logic             tick;
  logic             ctl_wr;
  logic             cfg_wr;
  logic             stat_wr;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             ew_evt;
  logic [CNT_W-1:0] win_q;
  logic [1:0]       psc_q;
  logic             ewi_q;
  logic             flag_q;

  assign ctl_wr  = bus_wr && (wd_addr_e'(bus_addr) == ADDR_CTRL);
  assign cfg_wr  = bus_wr && (wd_addr_e'(bus_addr) == ADDR_CFG);
  assign stat_wr = bus_wr && (wd_addr_e'(bus_addr) == ADDR_STAT);

  win_wdog_timebase #(.BASE_DIV(BASE_DIV)) u_tb (
    .clk  (clk),
    .rst_n(rst_n),
    .psc  (psc_q),
    .tick (tick)
  );

  win_wdog_core u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .ctl_wr  (ctl_wr),
    .ctl_data(bus_wdata[7:0]),
    .win     (win_q),
    .cnt_q   (cnt_q),
    .en_q    (en_q),
    .ew_evt  (ew_evt),
    .rst_req (rst_req)
  );

  win_wdog_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_wr (cfg_wr),
    .stat_wr(stat_wr),
    .wdata  (bus_wdata),
    .ew_evt (ew_evt),
    .win_q  (win_q),
    .psc_q  (psc_q),
    .ewi_q  (ewi_q),
    .flag_q (flag_q)
  );

  always_comb begin
    case (wd_addr_e'(bus_addr))
      ADDR_CTRL: bus_rdata = {2'b00, en_q, cnt_q};
      ADDR_CFG:  bus_rdata = {ewi_q, psc_q, win_q};
      ADDR_STAT: bus_rdata = {{(REG_W-1){1'b0}}, flag_q};
      default:   bus_rdata = '0;
    endcase
  end

  assign early_irq = flag_q & ewi_q;

endmodule

// File: rtl/win_watchdog_checker.sv
module win_watchdog_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       ctl_wr,
  input logic [6:0] cnt_q,
  input logic       en_q,
  input logic [6:0] win_q,
  input logic       ewi_q,
  input logic       flag_q,
  input logic       rst_req
);

  assert_cnt_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ($past(ctl_wr) || ($past(tick) && $past(en_q))));

  assert_en_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_q) |-> en_q);

  assert_ewi_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ewi_q) |-> ewi_q);

  assert_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_q) && $past(tick) && !$past(ctl_wr) && ($past(cnt_q) == 7'h40)) |-> rst_req);

  assert_early_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_wr) && $past(en_q) && ($past(cnt_q) > $past(win_q))) |-> rst_req);

  assert_flag_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(tick) && ($past(cnt_q) == 7'h41)));

  assert_req_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(en_q) && ($past(ctl_wr) || $past(tick))));

endmodule

bind win_watchdog win_watchdog_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .ctl_wr (ctl_wr),
  .cnt_q  (cnt_q),
  .en_q   (en_q),
  .win_q  (win_q),
  .ewi_q  (ewi_q),
  .flag_q (flag_q),
  .rst_req(rst_req)
);

// File: tb/win_watchdog_bench.sv
module win_watchdog_bench;

  localparam int BD = 4;
  localparam int NV = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [9:0] bus_wdata = '0;
  logic [9:0] bus_rdata;
  logic       rst_req;
  logic       early_irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  win_watchdog #(.BASE_DIV(BD)) u_win_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req), .early_irq(early_irq)
  );

  // Reference model, written from the requirements.
  int         m_pre;
  logic [6:0] m_cnt, m_win;
  logic [1:0] m_psc;
  logic       m_en, m_ewi, m_flag, m_rst;

  always @(posedge clk or negedge rst_n) begin : model
    int   per;
    logic hit, wc;
    if (!rst_n) begin
      m_pre <= 0; m_cnt <= 7'h7F; m_win <= 7'h7F; m_psc <= 2'd0;
      m_en <= 1'b0; m_ewi <= 1'b0; m_flag <= 1'b0; m_rst <= 1'b0;
    end else begin
      per = BD << m_psc;
      hit = ((m_pre % per) == per - 1);
      wc  = bus_wr && (bus_addr == 2'd0);
      m_rst <= (wc && m_en && (m_cnt > m_win)) ||
               (!wc && m_en && hit && (m_cnt == 7'h40));
      if (wc) m_cnt <= bus_wdata[6:0];
      else if (m_en && hit) m_cnt <= m_cnt - 7'd1;
      if (wc && bus_wdata[7]) m_en <= 1'b1;
      if (bus_wr && bus_addr == 2'd1) begin
        m_win <= bus_wdata[6:0];
        m_psc <= bus_wdata[8:7];
        if (bus_wdata[9]) m_ewi <= 1'b1;
      end
      if (!wc && m_en && hit && (m_cnt == 7'h41)) m_flag <= 1'b1;
      else if (bus_wr && bus_addr == 2'd2 && !bus_wdata[0]) m_flag <= 1'b0;
      m_pre <= (m_pre + 1) % (BD * 8);
    end
  end

  function automatic logic [9:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {2'b00, m_en, m_cnt};
      2'd1:    return {m_ewi, m_psc, m_win};
      2'd2:    return {9'd0, m_flag};
      default: return 10'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (rst_n) begin
      chk("R5 R6 R9 rst_req", 32'(rst_req), 32'(m_rst));
      chk("R7 R8 early_irq", 32'(early_irq), 32'(m_flag & m_ewi));
      chk("R2 R3 R4 R7 readback", 32'(bus_rdata), 32'(exp_rd(bus_addr)));
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      bus_addr = 2'(i % 3);
      cyc();
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  // {write, addr[1:0], data[9:0], idle cycles[11:0]}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 2'd0, 10'h030, 12'd20},   // disabled load, no steps (R2, R3)
    {1'b1, 2'd1, 10'h27F, 12'd8},    // irq enable, psc 0 (R4)
    {1'b1, 2'd0, 10'h0C5, 12'd40},   // start at 0x45: warning then timeout (R5, R7)
    {1'b1, 2'd2, 10'h001, 12'd6},    // bit0=1 keeps flag (R7)
    {1'b1, 2'd2, 10'h000, 12'd6},    // clear flag (R7)
    {1'b1, 2'd1, 10'h0D0, 12'd8},    // window 0x50, psc 1, bit9=0 ignored (R4)
    {1'b1, 2'd0, 10'h07F, 12'd400},  // reload above window (R6)
    {1'b1, 2'd0, 10'h060, 12'd30},   // reload inside window (R6)
    {1'b1, 2'd1, 10'h150, 12'd600},  // psc 2, run into timeout (R2, R5)
    {1'b1, 2'd1, 10'h1D0, 12'd40},   // psc 3
    {1'b1, 2'd0, 10'h045, 12'd300},  // reload, enable bit 0 ignored (R3)
    {1'b1, 2'd2, 10'h000, 12'd10}
  };

  initial begin
    int pulses;
    repeat (3) @(negedge clk);
    // R1: reset values while reset is asserted
    bus_addr = 2'd0; #0; chk("R1 ctrl", 32'(bus_rdata), 32'h07F);
    bus_addr = 2'd1; #1; chk("R1 cfg", 32'(bus_rdata), 32'h07F);
    bus_addr = 2'd2; #1; chk("R1 status", 32'(bus_rdata), 32'h000);
    bus_addr = 2'd3; #1; chk("R1 unused addr", 32'(bus_rdata), 32'h000);
    chk("R1 outputs", 32'({rst_req, early_irq}), 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][24]) wr(VEC[v][23:22], VEC[v][21:12]);
      idle(int'(VEC[v][11:0]));
    end

    // R4: interrupt enable cannot be cleared by a write
    wr(2'd1, 10'h000);
    bus_addr = 2'd1; cyc(); chk("R4 ewi set-only", 32'(bus_rdata[9]), 32'd1);
    // R3: enable cannot be cleared by a write
    wr(2'd0, 10'h010);
    bus_addr = 2'd0; cyc(); chk("R3 enable set-only", 32'(bus_rdata[7]), 32'd1);

    // R1: hardware reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    bus_addr = 2'd0; cyc(); chk("R1 ctrl after reset", 32'(bus_rdata), 32'h07F);
    bus_addr = 2'd1; cyc(); chk("R1 cfg after reset", 32'(bus_rdata), 32'h07F);

    // R2: disabled counter holds its value
    bus_addr = 2'd0; repeat (40) cyc();
    chk("R2 disabled hold", 32'(bus_rdata), 32'h07F);

    // R9: one pulse for one timeout
    wr(2'd1, 10'h27F);
    wr(2'd0, 10'h0C1);
    pulses = 0;
    for (int i = 0; i < 16; i++) begin
      bus_addr = 2'd2;
      cyc();
      if (rst_req) pulses++;
    end
    chk("R9 single pulse", 32'(pulses), 32'd1);
    chk("R8 irq after warning", 32'(early_irq), 32'd1);

    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

endmodule